// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers the interrupt sources of one I/O channel into a single request line. Six one-cycle event pulses arrive from the channel: read-DMA done, write-DMA done, read-DMA error, write-DMA error, a local FIFO condition and an external interrupt. Each pulse sets a sticky flag. A flag stays set until software writes a one to its position in the status register.

A control register holds a master enable, a software force bit and one enable per source. The request line is registered. It goes high when the master enable is set and either the force bit is set or some enabled flag is set. Software reads the status word through a small read port. The top bit of that word mirrors the request line, so one read shows why the channel is interrupting. All pins are plain control and status signals. No data stream crosses the block, so no port carries a valid/ready handshake.

Register map. Address 0 is control, read/write. Bit 0 is the master enable, bit 1 is force, and bits 7:2 are the enables for sources 0 to 5. Address 1 is status, read with write-one-to-clear. Bits 5:0 are the source flags, in the order rd_done, wr_done, rd_err, wr_err, local, ext. Bit 31 is the summary.

Top module: `irq_status_ctrl`

## Requirements
- R1: When control bit 0 (master enable) is 0, irq_o is 0 in the cycle after, whatever the flags and the force bit hold.
- R2: With control bits 0 and 1 both set, irq_o is 1 in the cycle after, even when all flags are 0.
- R3: A pulse on an event input sets its status flag at the next clock edge. The flag positions are rd_done bit 0, wr_done bit 1, rd_err bit 2, wr_err bit 3, local bit 4 and ext bit 5. The flag then holds until it is cleared.
- R4: A write to address 1 clears each flag whose wr_data bit is 1 and leaves unchanged each flag whose wr_data bit is 0.
- R5: A flag whose event pulse arrives in the same cycle as its clear write stays set.
- R6: Bit 31 of the status word read at address 1 equals irq_o. Bits 30:6 read 0.
- R7: A set flag contributes to the request only when its enable is set. Control bit 2+i enables source i, so bit 7 enables the external interrupt.
- R8: irq_o is registered. It follows a change of the flags or the control register one clock edge after that change, so it deasserts in the cycle after the last enabled flag is cleared.
- R9: A synchronous reset clears every flag, every control bit and irq_o.
- R10: Reading address 0 returns the control register in bits 7:0 and 0 in the bits above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_rd_done | input | 1 | Read-DMA done pulse |
| ev_wr_done | input | 1 | Write-DMA done pulse |
| ev_rd_err | input | 1 | Read-DMA error pulse |
| ev_wr_err | input | 1 | Write-DMA error pulse |
| ev_local | input | 1 | Local FIFO condition pulse |
| ev_ext | input | 1 | External interrupt pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects control, 1 selects status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 selects control, 1 selects status |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every value of the eight control bits. For each value it latches a different pattern of flags and compares irq_o and the summary bit with the value it computes from the control bits and the flags.

One check pulses a source in the same cycle as a clear write that covers it. A design that lets the clear win would drop that flag.

Another check writes zero to the status register. A design that loads the status register from the data instead of clearing bit by bit would wipe every flag.

The bench also samples irq_o before and after the edge that follows a clear. A design with a combinational request, or with one extra register stage, would show the wrong value in one of those two samples.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC     = 6;
  localparam int DATA_W      = 32;
  localparam int CTRL_MASTER = 0;
  localparam int CTRL_FORCE  = 1;
  localparam int CTRL_EN_LSB = 2;
  localparam int CTRL_W      = CTRL_EN_LSB + NUM_SRC;
  localparam int SRC_RD_DONE = 0;
  localparam int SRC_WR_DONE = 1;
  localparam int SRC_RD_ERR  = 2;
  localparam int SRC_WR_ERR  = 3;
  localparam int SRC_LOCAL   = 4;
  localparam int SRC_EXT     = 5;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= (flag_q & ~clr_i[i]) | set_i[i];
    end
    assign flag_o[i] = flag_q;

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q);
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flag_q);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !clr_i[i]) |=> flag_q);
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (we_i) ctrl_q <= d_i;
  end
  assign q_o = ctrl_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master_i,
  input  logic         force_i,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;
  logic any_src;
  always_comb any_src = |(flag_i & en_i);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= master_i & (force_i | any_src);
  end
  assign irq_o = irq_q;

  assert_master_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !master_i |=> !irq_q);
  assert_force_R2: assert property (@(posedge clk) disable iff (rst)
    (master_i && force_i) |=> irq_q);
  assert_no_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_i == '0 && !force_i) |=> !irq_q);
  assert_reset_R9: assert property (@(posedge clk) rst |=> !irq_q);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_rd_done,
  input  logic              ev_wr_done,
  input  logic              ev_rd_err,
  input  logic              ev_wr_err,
  input  logic              ev_local,
  input  logic              ev_ext,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] ev_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] flags;
  logic [CTRL_W-1:0]  ctrl;
  logic               ctrl_we;
  logic               irq_q;
  logic               unused_wr_hi;

  always_comb begin
    ev_vec              = '0;
    ev_vec[SRC_RD_DONE] = ev_rd_done;
    ev_vec[SRC_WR_DONE] = ev_wr_done;
    ev_vec[SRC_RD_ERR]  = ev_rd_err;
    ev_vec[SRC_WR_ERR]  = ev_wr_err;
    ev_vec[SRC_LOCAL]   = ev_local;
    ev_vec[SRC_EXT]     = ev_ext;
  end

  assign ctrl_we      = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_vec      = (wr_en && (wr_addr == ADDR_STAT)) ? wr_data[NUM_SRC-1:0] : '0;
  assign unused_wr_hi = ^wr_data[DATA_W-1:CTRL_W];

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(ev_vec), .clr_i(clr_vec), .flag_o(flags)
  );

  irq_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .we_i(ctrl_we), .d_i(wr_data[CTRL_W-1:0]), .q_o(ctrl)
  );

  irq_req_gate #(.N(NUM_SRC)) u_gate (
    .clk(clk), .rst(rst),
    .master_i(ctrl[CTRL_MASTER]), .force_i(ctrl[CTRL_FORCE]),
    .flag_i(flags), .en_i(ctrl[CTRL_EN_LSB +: NUM_SRC]),
    .irq_o(irq_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) begin
      rd_data[CTRL_W-1:0] = ctrl;
    end else begin
      rd_data[NUM_SRC-1:0] = flags;
      rd_data[DATA_W-1]    = irq_q;
    end
  end

  assign irq_o = irq_q;

  assert_reset_flags_R9: assert property (@(posedge clk) rst |=> (flags == '0 && ctrl == '0));
  assert_enable_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[CTRL_FORCE] && (flags & ctrl[CTRL_EN_LSB +: NUM_SRC]) == '0) |=> !irq_q);
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  ev;
  logic        wr_en, wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst(rst),
    .ev_rd_done(ev[0]), .ev_wr_done(ev[1]), .ev_rd_err(ev[2]),
    .ev_wr_err(ev[3]), .ev_local(ev[4]), .ev_ext(ev[5]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic calc_irq(logic [7:0] c, logic [5:0] f);
    return c[0] & (c[1] | |(f & c[7:2]));
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] p, m, st;
    logic [7:0] c;
    int e;
    rst = 1'b1; ev = '0; wr_en = 0; wr_addr = 0; wr_data = '0; rd_addr = 1;
    step(); step();
    rst = 1'b0;
    step();
    check("R9 irq after reset", {31'd0, irq_o}, 32'd0);
    check("R9 status after reset", rd_data, 32'd0);
    rd_addr = 0; #1;
    check("R9 control after reset", rd_data, 32'd0);

    for (int k = 0; k < 256; k++) begin
      c = k[7:0];
      p = 6'((k * 37 + 11) & 63);
      e = k % 6;
      // write control
      wr_en = 1; wr_addr = 0; wr_data = {24'hABCDEF, c};
      step();
      wr_en = 0; rd_addr = 0; #1;
      check("R10 control readback", rd_data, {24'd0, c});
      // pulse events
      ev = p;
      step();
      ev = '0; rd_addr = 1; #1;
      check("R3 flags latched", {26'd0, rd_data[5:0]}, {26'd0, p});
      step();
      check("R1 R2 R7 irq", {31'd0, irq_o}, {31'd0, calc_irq(c, p)});
      check("R6 summary bit", rd_data, {calc_irq(c, p), 25'd0, p});
      // write zeros to status: no change
      wr_en = 1; wr_addr = 1; wr_data = 32'd0;
      step();
      wr_en = 0; #1;
      check("R4 zero write keeps flags", {26'd0, rd_data[5:0]}, {26'd0, p});
      // partial clear with simultaneous event
      m = p | 6'h15;
      wr_en = 1; wr_addr = 1; wr_data = {26'd0, m};
      ev = 6'(1 << e);
      step();
      wr_en = 0; ev = '0; #1;
      st = (p & ~m) | 6'(1 << e);
      check("R4 R5 clear and set", {26'd0, rd_data[5:0]}, {26'd0, st});
      check("R8 irq not yet updated", {31'd0, irq_o}, {31'd0, calc_irq(c, p)});
      step();
      check("R8 irq after clear", {31'd0, irq_o}, {31'd0, calc_irq(c, st)});
      // clear all
      wr_en = 1; wr_addr = 1; wr_data = 32'hFFFF_FFFF;
      step();
      wr_en = 0; #1;
      check("R4 all cleared", {26'd0, rd_data[5:0]}, 32'd0);
      step();
      check("R2 R8 irq idle", {31'd0, irq_o}, {31'd0, c[0] & c[1]});
    end

    // reset mid-run with state present
    wr_en = 1; wr_addr = 0; wr_data = 32'hFF;
    ev = 6'h3F;
    step();
    wr_en = 0; ev = '0;
    step();
    check("R3 before reset", {31'd0, irq_o}, 32'd1);
    rst = 1;
    step();
    rst = 0; rd_addr = 1; #1;
    check("R9 status cleared", rd_data, 32'd0);
    check("R9 irq cleared", {31'd0, irq_o}, 32'd0);
    rd_addr = 0; #1;
    check("R9 control cleared", rd_data, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule